// File: doc/BRIEF.md
# Masked Sticky Fault Interrupt Collector

This block gathers eight internal fault indications (speaker over-current, speaker over-voltage, two clock-error detectors, over-temperature, brownout, word-clock halt and modulator-clock halt) into latched status bits. The status bits are spread across two byte-wide status registers that clear when the host reads them. A single 8-bit enable mask selects which latched faults can raise the one interrupt request line.

The host reads the status registers through a simple read port, which has an address and a one-cycle read strobe. The status bytes are presented continuously, so the value the host samples in a read cycle is the one that gets cleared at the end of that cycle. Once the interrupt has been raised, it is held until both status registers have been read. Completing that pair of reads also emits a one-cycle "all read" pulse, which a downstream pin controller can use. The mask is loaded through a write strobe and data byte.

Fault vector layout, used for both the `fault_i` port and the mask:

| Bit | Fault |
|-----|-------|
| 7 | over-current |
| 6 | over-voltage |
| 5 | clock error 1 |
| 4 | over-temperature |
| 3 | brownout |
| 2 | clock error 2 |
| 1 | word-clock halt |
| 0 | modulator-clock halt |

Top module: `irq_flag_agg`

## Requirements
- R1: A latched status bit is set at the clock edge following any cycle in which its raw fault input is high.
- R2: Status byte 1 shows the faults of vector bits 7 to 2 at bits 7 to 2, with bits 1 and 0 reading zero. Status byte 2 shows word-clock halt at bit 7 and modulator-clock halt at bit 6, with bits 5 to 0 reading zero.
- R3: A read strobe with address 0 clears the latched bits of status byte 1 at the next edge, except for any bit whose raw fault is high in that cycle, which stays set.
- R4: A read strobe with address 1 clears the latched bits of status byte 2 at the next edge, except for any bit whose raw fault is high in that cycle.
- R5: With no read strobe, or with a read of any other address, latched bits hold their value.
- R6: Mask bit k enables fault vector bit k. The interrupt is the OR of all latched bits whose mask bit is set. With mask 0x88 only brownout and over-current raise it.
- R7: Once raised, the interrupt stays high until both addresses 0 and 1 have been read since it rose. At the edge that completes the pair it drops, unless a masked latched bit is still set.
- R8: At the edge that completes both reads after an interrupt rise, `clr_done_o` goes high for exactly one cycle. Later read pairs give no pulse until the interrupt rises again.
- R9: After reset, every status bit, the interrupt and the pulse are low, and the mask is 0x00, so no fault can raise the interrupt.
- R10: A mask write strobe loads the mask byte at the clock edge. The new mask takes effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fault_i | input | 8 | Raw fault flags in the vector layout above |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 8 | Mask value to load |
| rd_en_i | input | 1 | Status read strobe |
| rd_addr_i | input | 2 | Status register address (0 = byte 1, 1 = byte 2) |
| stat1_o | output | 8 | Status byte 1 |
| stat2_o | output | 8 | Status byte 2 |
| irq_o | output | 1 | Interrupt request, active high |
| clr_done_o | output | 1 | One-cycle pulse when both status bytes have been read |

## Verification
Several properties are checked on every cycle:
- a fault always latches;
- latched bits hold when no read is made;
- a fault-free read of byte 1 empties it;
- the unused bits stay zero;
- a masked latched bit with a stable mask always has the interrupt high;
- the interrupt falls only after a read;
- the pulse never lasts two cycles.

Some behaviour can only be shown by the bench scenarios. This covers the read-pair bookkeeping: the interrupt staying high after just one read, no pulse on a second pair of reads, and the pulse firing while a still-active fault keeps the interrupt high. It also covers the 0x88 routing and the one-cycle delay before a written mask takes effect. Those scenarios, and a long random run, are compared cycle by cycle against a reference model.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned FLAG_W  = 8;  // number of fault flags
  localparam int unsigned REG_W   = 8;  // status register width
  localparam int unsigned SPLIT   = 2;  // flags below this index live in byte 2
  localparam int unsigned ADDR_W  = 2;
  localparam logic [ADDR_W-1:0] ADDR_STAT1 = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT2 = 2'd1;
  typedef logic [FLAG_W-1:0] flag_vec_t;
endpackage

// File: rtl/flag_sticky_bank.sv
module flag_sticky_bank #(
  parameter int unsigned N     = 8,
  parameter int unsigned SPLIT = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] raw_i,
  input  logic         clr_hi_i,   // clears bits N-1..SPLIT
  input  logic         clr_lo_i,   // clears bits SPLIT-1..0
  output logic [N-1:0] sticky_n_o,
  output logic [N-1:0] sticky_q_o
);
  logic [N-1:0] sticky_q;
  logic [N-1:0] sticky_n;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic clr_sel;
    if (i >= SPLIT) begin : g_hi
      assign clr_sel = clr_hi_i;
    end else begin : g_lo
      assign clr_sel = clr_lo_i;
    end
    // A raw fault in the clearing cycle wins over the clear
    always_comb begin
      sticky_n[i] = raw_i[i] | (sticky_q[i] & ~clr_sel);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sticky_q <= '0;
    end else begin
      sticky_q <= sticky_n;
    end
  end

  assign sticky_n_o = sticky_n;
  assign sticky_q_o = sticky_q;
endmodule

// File: rtl/read_pair_tracker.sv
module read_pair_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd1_i,
  input  logic rd2_i,
  input  logic irq_rise_i,
  output logic complete_o,
  output logic clr_pulse_o
);
  logic seen1_q, seen1_n;
  logic seen2_q, seen2_n;
  logic armed_q, armed_n;
  logic pulse_q, pulse_n;
  logic complete;

  always_comb begin
    complete = (seen1_q | rd1_i) & (seen2_q | rd2_i);
    pulse_n  = armed_q & complete;
    if (irq_rise_i || complete) begin
      seen1_n = 1'b0;
      seen2_n = 1'b0;
    end else begin
      seen1_n = seen1_q | rd1_i;
      seen2_n = seen2_q | rd2_i;
    end
    if (irq_rise_i) begin
      armed_n = 1'b1;
    end else if (complete) begin
      armed_n = 1'b0;
    end else begin
      armed_n = armed_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen1_q <= 1'b0;
      seen2_q <= 1'b0;
      armed_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      seen1_q <= seen1_n;
      seen2_q <= seen2_n;
      armed_q <= armed_n;
      pulse_q <= pulse_n;
    end
  end

  assign complete_o  = complete;
  assign clr_pulse_o = pulse_q;
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sticky_n_i,
  input  logic [N-1:0] mask_i,
  input  logic         complete_i,
  output logic         irq_o,
  output logic         rise_o
);
  logic irq_q, irq_n;

  always_comb begin
    irq_n = (|(sticky_n_i & mask_i)) | (irq_q & ~complete_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_n;
    end
  end

  assign irq_o  = irq_q;
  assign rise_o = irq_n & ~irq_q;
endmodule

// File: rtl/irq_flag_agg.sv
module irq_flag_agg
  import irq_agg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] fault_i,
  input  logic              mask_we_i,
  input  logic [FLAG_W-1:0] mask_wdata_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  stat1_o,
  output logic [REG_W-1:0]  stat2_o,
  output logic              irq_o,
  output logic              clr_done_o
);
  localparam int unsigned HI_W = FLAG_W - SPLIT;

  flag_vec_t mask_q, mask_n;
  flag_vec_t sticky_q, sticky_n;
  logic rd1, rd2;
  logic complete, irq_rise;

  // Mask register with explicit clock enable
  always_comb begin
    mask_n = mask_we_i ? mask_wdata_i : mask_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else begin
      mask_q <= mask_n;
    end
  end

  assign rd1 = rd_en_i & (rd_addr_i == ADDR_STAT1);
  assign rd2 = rd_en_i & (rd_addr_i == ADDR_STAT2);

  flag_sticky_bank #(.N(FLAG_W), .SPLIT(SPLIT)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .raw_i      (fault_i),
    .clr_hi_i   (rd1),
    .clr_lo_i   (rd2),
    .sticky_n_o (sticky_n),
    .sticky_q_o (sticky_q)
  );

  read_pair_tracker u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd1_i       (rd1),
    .rd2_i       (rd2),
    .irq_rise_i  (irq_rise),
    .complete_o  (complete),
    .clr_pulse_o (clr_done_o)
  );

  irq_merge #(.N(FLAG_W)) u_merge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sticky_n_i (sticky_n),
    .mask_i     (mask_q),
    .complete_i (complete),
    .irq_o      (irq_o),
    .rise_o     (irq_rise)
  );

  assign stat1_o = {sticky_q[FLAG_W-1:SPLIT], {(REG_W-HI_W){1'b0}}};
  assign stat2_o = {sticky_q[SPLIT-1:0], {(REG_W-SPLIT){1'b0}}};
endmodule

// File: rtl/irq_flag_agg_chk.sv
module irq_flag_agg_chk
  import irq_agg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [FLAG_W-1:0] fault_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [REG_W-1:0]  stat1_o,
  input logic [REG_W-1:0]  stat2_o,
  input logic              irq_o,
  input logic              clr_done_o,
  input logic [FLAG_W-1:0] mask_q
);
  logic [FLAG_W-1:0] cur;
  assign cur = {stat1_o[7:2], stat2_o[7:6]};

  a_r1_fault_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_i != '0) |=> ((cur & $past(fault_i)) == $past(fault_i)));

  a_r2_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat1_o[1:0] == 2'b00) && (stat2_o[5:0] == 6'b0));

  a_r3_read1_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_addr_i == ADDR_STAT1 && fault_i == '0) |=> (stat1_o == '0));

  a_r5_hold_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> ((cur & $past(cur)) == $past(cur)));

  a_r6_masked_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((cur & mask_q) != '0) && $stable(mask_q)) |-> irq_o);

  a_r7_fall_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(rd_en_i));

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_done_o |=> !clr_done_o);

  a_r8_pulse_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clr_done_o) |-> $past(rd_en_i));
endmodule

bind irq_flag_agg irq_flag_agg_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fault_i    (fault_i),
  .rd_en_i    (rd_en_i),
  .rd_addr_i  (rd_addr_i),
  .stat1_o    (stat1_o),
  .stat2_o    (stat2_o),
  .irq_o      (irq_o),
  .clr_done_o (clr_done_o),
  .mask_q     (mask_q)
);

// File: tb/irq_flag_agg_tb.sv
module irq_flag_agg_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] fault = '0;
  logic       we = 1'b0;
  logic [7:0] wd = '0;
  logic       rd = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] stat1, stat2;
  logic       irq, clr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_flag_agg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fault_i(fault), .mask_we_i(we),
    .mask_wdata_i(wd), .rd_en_i(rd), .rd_addr_i(addr),
    .stat1_o(stat1), .stat2_o(stat2), .irq_o(irq), .clr_done_o(clr)
  );

  // Reference model: latched flags in vector order, read-pair bookkeeping
  bit [7:0] m_s, m_mask;
  bit m_irq, m_clr, m_arm, m_seen1, m_seen2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s = 0; m_mask = 0; m_irq = 0; m_clr = 0;
      m_arm = 0; m_seen1 = 0; m_seen2 = 0;
    end else begin
      bit r1, r2, done, nirq;
      bit [7:0] ns;
      r1 = rd && (addr == 2'd0);
      r2 = rd && (addr == 2'd1);
      ns = m_s;
      for (int k = 0; k < 8; k++) begin
        if ((k >= 2 && r1) || (k < 2 && r2)) ns[k] = 1'b0;
        if (fault[k]) ns[k] = 1'b1;
      end
      done = (m_seen1 || r1) && (m_seen2 || r2);
      nirq = ((ns & m_mask) != 0) || (m_irq && !done);
      m_clr = m_arm && done;
      if (nirq && !m_irq) begin
        m_arm = 1; m_seen1 = 0; m_seen2 = 0;
      end else if (done) begin
        m_arm = 0; m_seen1 = 0; m_seen2 = 0;
      end else begin
        m_seen1 = m_seen1 || r1;
        m_seen2 = m_seen2 || r2;
      end
      m_irq = nirq;
      m_s = ns;
      if (we) m_mask = wd;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 stat1 vs model", stat1, {m_s[7:2], 2'b00});
      chk("R2 stat2 vs model", stat2, {m_s[1:0], 6'b0});
      chk("R7 irq vs model", {7'b0, irq}, {7'b0, m_irq});
      chk("R8 clr vs model", {7'b0, clr}, {7'b0, m_clr});
    end
  end

  task automatic cyc(logic [7:0] f, logic r, logic [1:0] a, logic w, logic [7:0] d);
    fault = f; rd = r; addr = a; we = w; wd = d;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset stat1", stat1, 8'h00);
    chk("R9 reset stat2", stat2, 8'h00);
    chk("R9 reset irq", {7'b0, irq}, 8'h00);
    rst_n = 1'b1;
    cyc(8'h00, 0, 0, 0, 0);
    // R9: mask is zero after reset, so a latched fault raises nothing
    cyc(8'h80, 0, 0, 0, 0);
    chk("R9 mask zero irq", {7'b0, irq}, 8'h00);
    chk("R1 over-current latched", stat1, 8'h80);
    cyc(8'h00, 1, 0, 0, 0);
    cyc(8'h00, 1, 1, 0, 0);
    chk("R3 byte1 cleared", stat1, 8'h00);
    // R10, R6: mask 0x88
    cyc(8'h00, 0, 0, 1, 8'h88);
    cyc(8'h40, 0, 0, 0, 0);
    chk("R6 over-voltage latched", stat1, 8'h40);
    chk("R6 over-voltage not routed", {7'b0, irq}, 8'h00);
    cyc(8'h00, 1, 0, 0, 0);
    cyc(8'h00, 1, 1, 0, 0);
    chk("R8 no pulse without irq", {7'b0, clr}, 8'h00);
    cyc(8'h08, 0, 0, 0, 0);
    chk("R6 brownout routed", {7'b0, irq}, 8'h01);
    chk("R10 mask active", stat1, 8'h08);
    cyc(8'h00, 1, 0, 0, 0);
    chk("R7 held after one read", {7'b0, irq}, 8'h01);
    cyc(8'h00, 0, 0, 0, 0);
    cyc(8'h00, 1, 1, 0, 0);
    chk("R7 dropped after both", {7'b0, irq}, 8'h00);
    chk("R8 pulse high", {7'b0, clr}, 8'h01);
    cyc(8'h00, 0, 0, 0, 0);
    chk("R8 pulse one cycle", {7'b0, clr}, 8'h00);
    // R4/R3: raw high during read keeps bit
    cyc(8'h00, 0, 0, 1, 8'hFF);
    cyc(8'h02, 0, 0, 0, 0);
    chk("R2 word-clock halt bit7", stat2, 8'h80);
    cyc(8'h02, 1, 1, 0, 0);
    chk("R4 stays while raw high", stat2, 8'h80);
    cyc(8'h00, 1, 1, 0, 0);
    chk("R4 cleared", stat2, 8'h00);
    cyc(8'h10, 1, 0, 0, 0);
    chk("R3 stays while raw high", stat1, 8'h10);
    chk("R8 pulse on completion", {7'b0, clr}, 8'h01);
    chk("R7 held by masked bit", {7'b0, irq}, 8'h01);
    cyc(8'h00, 1, 0, 0, 0);
    cyc(8'h00, 1, 1, 0, 0);
    chk("R7 dropped", {7'b0, irq}, 8'h00);
    chk("R8 no second pulse", {7'b0, clr}, 8'h00);
    // R5: hold without read and with other address
    cyc(8'h01, 0, 0, 0, 0);
    repeat (4) cyc(8'h00, 0, 0, 0, 0);
    chk("R5 held idle", stat2, 8'h40);
    cyc(8'h00, 1, 2, 0, 0);
    chk("R5 held other addr", stat2, 8'h40);
    cyc(8'h00, 1, 1, 0, 0);
    cyc(8'h00, 1, 0, 0, 0);
    // Random phase
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] f;
      f = (($urandom % 6) == 0) ? (8'h01 << ($urandom % 8)) : 8'h00;
      cyc(f, (($urandom % 4) == 0), 2'($urandom % 4),
          (($urandom % 50) == 0), 8'($urandom));
    end
    cyc(8'h00, 0, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule